// File: doc/BRIEF.md
# Vector Rounding Shift-Right Narrow Unit

This unit takes a packed vector of wide unsigned elements and a 32-bit instruction word. It decodes a narrow element size and a shift amount from one combined size/immediate field. Each wide element is extended by one bit and has a rounding constant of half the shift weight added to it. The sum is shifted right, and its low half-width bits become the narrowed value. The narrowed values fill the even half-width lanes of the result. Every odd half-width lane is forced to zero.

The block sits in a vector execution pipe as one stage. Register reads and writes happen outside it. On a `in_valid` strobe it captures the outcome into output registers, so the result appears exactly one clock later, whatever the operand values. An encoding that is reserved or malformed produces an undefined-encoding flag instead of a valid result. The vector width `VLEN` is a parameter and must be a multiple of 128 bits.

Top module: `rsn_unit`

## Requirements
- R1: If the 3-bit size code {instr[22], instr[20:19]} equals 000, the encoding is undefined: `out_undef` rises one cycle later, `out_valid` stays low and `result` is all zeros.
- R2: The fixed fields must be instr[31:23]=010001010, instr[21]=1 and instr[15:10]=000110. Any mismatch in these fields is treated as undefined, with the same outputs as R1.
- R3: The narrow width depends on the size code. Code 001 selects 8 bits, codes 010 and 011 select 16 bits, and codes 1xx select 32 bits. Source elements are twice the narrow width.
- R4: The shift amount is 2×narrow width minus the unsigned 6-bit value {size code, instr[18:16]}. This gives 1 up to the narrow width.
- R5: Each narrowed value is (element + 2^(shift−1)) >> shift, evaluated without losing the carry of the addition.
- R6: Only the low narrow-width bits of each rounded value are kept, so higher bits are dropped.
- R7: Wide element e fills half-width lane 2e, and half-width lane 2e+1 is all zeros.
- R8: All VLEN/(2×narrow width) elements are processed, with no masking.
- R9: The outputs update exactly one cycle after `in_valid` and hold while `in_valid` is low. In the cycle after a strobe exactly one of `out_valid`/`out_undef` is high. Both are low in the cycle after an idle cycle.
- R10: After synchronous reset, `out_valid`, `out_undef` and `result` are all zero.
- R11: The register index fields instr[9:5] and instr[4:0] have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| instr | input | 32 | Instruction word |
| src | input | VLEN | Source vector of wide elements |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| out_undef | output | 1 | Undefined-encoding flag, one cycle after strobe |
| result | output | VLEN | Interleaved narrowed result |

## Verification
The three sizes are driven with shifts of 1 and of the full narrow width. Against a reference model, these separate the size decode from the shift arithmetic. Operands just below and at a rounding boundary expose a missing or misplaced rounding constant. All-ones operands check truncation and carry handling, and hashed operands catch lane misplacement and odd-lane leakage. Reserved and corrupted fixed fields, varied register indices, and back-to-back and idle strobes check the undefined path, that the indices are ignored, and the fixed latency.

// File: rtl/vrsn_pkg.sv
package vrsn_pkg;

    typedef enum logic [1:0] {
        NW_8  = 2'd0,
        NW_16 = 2'd1,
        NW_32 = 2'd2
    } nsize_e;

    localparam logic [8:0] OPC_TOP = 9'b010001010;
    localparam logic [5:0] OPC_MID = 6'b000110;

    typedef struct packed {
        logic       undef;
        nsize_e     nsize;
        logic [5:0] shamt;
    } dec_t;

    function automatic nsize_e size_of(input logic [2:0] code);
        if (code[2])      return NW_32;
        else if (code[1]) return NW_16;
        else              return NW_8;
    endfunction

    function automatic logic [6:0] twice_width(input nsize_e s);
        case (s)
            NW_8:    return 7'd16;
            NW_16:   return 7'd32;
            default: return 7'd64;
        endcase
    endfunction

    function automatic logic [5:0] shift_of(input logic [2:0] code, input logic [2:0] imm3);
        logic [6:0] diff;
        diff = twice_width(size_of(code)) - {1'b0, code, imm3};
        return diff[5:0];
    endfunction

endpackage

// File: rtl/vrsn_decode.sv
module vrsn_decode
    import vrsn_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [2:0] code;
    logic       fixed_ok;

    always_comb begin
        code     = {instr[22], instr[20:19]};
        fixed_ok = (instr[31:23] == OPC_TOP) && instr[21] && (instr[15:10] == OPC_MID);
        dec.undef = !fixed_ok || (code == 3'b000);
        dec.nsize = size_of(code);
        dec.shamt = shift_of(code, instr[18:16]);
    end
endmodule

// File: rtl/vrsn_round_lane.sv
module vrsn_round_lane #(
    parameter int NW = 8
) (
    input  logic [2*NW-1:0] wide,
    input  logic [5:0]      shamt,
    output logic [NW-1:0]   narrow
);
    localparam int WW = 2 * NW;

    logic [WW:0] one;
    logic [WW:0] rnd;
    logic [WW:0] sum;
    logic [WW:0] shifted;

    always_comb begin
        one     = {{WW{1'b0}}, 1'b1};
        rnd     = (shamt == 6'd0) ? '0 : (one << (shamt - 6'd1));
        sum     = {1'b0, wide} + rnd;
        shifted = sum >> shamt;
        narrow  = shifted[NW-1:0];
    end
endmodule

// File: rtl/vrsn_size_path.sv
module vrsn_size_path #(
    parameter int VLEN = 128,
    parameter int NW   = 8
) (
    input  logic [VLEN-1:0] src,
    input  logic [5:0]      shamt,
    output logic [VLEN-1:0] packed_out
);
    localparam int WW    = 2 * NW;
    localparam int NELEM = VLEN / WW;

    for (genvar e = 0; e < NELEM; e++) begin : g_elem
        logic [NW-1:0] nar;
        vrsn_round_lane #(.NW(NW)) u_lane (
            .wide   (src[e*WW +: WW]),
            .shamt  (shamt),
            .narrow (nar)
        );
        assign packed_out[e*WW +: NW]      = nar;
        assign packed_out[e*WW + NW +: NW] = '0;
    end
endmodule

// File: rtl/rsn_unit.sv
module rsn_unit
    import vrsn_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [VLEN-1:0] src,
    output logic            out_valid,
    output logic            out_undef,
    output logic [VLEN-1:0] result
);
    localparam int NSIZES = 3;

    dec_t            dec;
    logic [VLEN-1:0] cand [NSIZES];
    logic [VLEN-1:0] chosen;

    vrsn_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    for (genvar i = 0; i < NSIZES; i++) begin : g_size
        vrsn_size_path #(.VLEN(VLEN), .NW(8 << i)) u_path (
            .src        (src),
            .shamt      (dec.shamt),
            .packed_out (cand[i])
        );
    end

    always_comb begin
        case (dec.nsize)
            NW_8:    chosen = cand[0];
            NW_16:   chosen = cand[1];
            default: chosen = cand[2];
        endcase
        if (dec.undef) chosen = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_undef <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid && !dec.undef;
            out_undef <= in_valid && dec.undef;
            if (in_valid) result <= chosen;
        end
    end
endmodule

// File: rtl/vrsn_chk.sv
module vrsn_chk
    import vrsn_pkg::*;
#(
    parameter int VLEN = 128
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [31:0]     instr,
    input logic            out_valid,
    input logic            out_undef,
    input logic [VLEN-1:0] result
);
    nsize_e sz_q;

    always_ff @(posedge clk) begin
        if (rst) sz_q <= NW_8;
        else if (in_valid) sz_q <= size_of({instr[22], instr[20:19]});
    end

    function automatic logic [VLEN-1:0] odd_mask(input nsize_e s);
        logic [VLEN-1:0] m;
        int nw;
        nw = 8 << int'(s);
        for (int i = 0; i < VLEN; i++) m[i] = ((i / nw) % 2) == 1;
        return m;
    endfunction

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!out_valid && !out_undef && result == '0)); // R10
    AST_STROBE_RESPONSE: assert property (@(posedge clk) disable iff (rst) in_valid |=> $countones({out_valid, out_undef}) == 1); // R9
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && !out_undef)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(result)); // R9
    AST_RESERVED_CODE: assert property (@(posedge clk) disable iff (rst) (in_valid && !instr[22] && instr[20:19] == 2'b00) |=> out_undef); // R1
    AST_FIXED_FIELDS: assert property (@(posedge clk) disable iff (rst) (in_valid && (instr[31:23] != OPC_TOP || !instr[21] || instr[15:10] != OPC_MID)) |=> out_undef); // R2
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst) out_undef |-> (result == '0 && !out_valid)); // R1
    AST_ODD_LANES_ZERO: assert property (@(posedge clk) disable iff (rst) out_valid |-> ((result & odd_mask(sz_q)) == '0)); // R7
endmodule

bind rsn_unit vrsn_chk #(.VLEN(VLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .instr     (instr),
    .out_valid (out_valid),
    .out_undef (out_undef),
    .result    (result)
);

// File: tb/test_rsn_unit.sv
module test_rsn_unit;
    localparam int VLEN = 256;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [VLEN-1:0] src = '0;
    logic            out_valid;
    logic            out_undef;
    logic [VLEN-1:0] result;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rsn_unit #(.VLEN(VLEN)) i_rsn_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .src(src),
        .out_valid(out_valid), .out_undef(out_undef), .result(result)
    );

    function automatic logic [31:0] enc(input int nw, input int sh, input logic [4:0] rn, input logic [4:0] rd);
        logic [5:0] imm6;
        imm6 = 6'(2 * nw - sh);
        return {9'b010001010, imm6[5], 1'b1, imm6[4:3], imm6[2:0], 6'b000110, rn, rd};
    endfunction

    function automatic logic [VLEN-1:0] model(input int nw, input int sh, input logic [VLEN-1:0] v);
        logic [VLEN-1:0] r;
        logic [127:0] w, full, lo;
        r = '0;
        full = (128'd1 << (2 * nw)) - 128'd1;
        lo   = (128'd1 << nw) - 128'd1;
        for (int e = 0; e < VLEN / (2 * nw); e++) begin
            w = 128'(v >> (e * 2 * nw)) & full;
            w = ((w + (128'd1 << (sh - 1))) >> sh) & lo;
            r = r | (VLEN'(w) << (e * 2 * nw));
        end
        return r;
    endfunction

    function automatic logic [VLEN-1:0] pat(input int seed);
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = 32'((seed + i) * 32'h9E3779B1 ^ (i * 32'h85EBCA6B));
        return v;
    endfunction

    task automatic chk(input string req, input string what, input logic [VLEN-1:0] got, input logic [VLEN-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic issue(input logic [31:0] ins, input logic [VLEN-1:0] v);
        @(negedge clk);
        in_valid = 1'b1; instr = ins; src = v;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_ok(input string req, input int nw, input int sh, input logic [VLEN-1:0] v);
        issue(enc(nw, sh, 5'd3, 5'd7), v);
        chk(req, "valid", VLEN'(out_valid), VLEN'(1));
        chk(req, "undef", VLEN'(out_undef), '0);
        chk(req, "data", result, model(nw, sh, v));
    endtask

    task automatic run_bad(input string req, input logic [31:0] ins);
        issue(ins, pat(77));
        chk(req, "undef", VLEN'(out_undef), VLEN'(1));
        chk(req, "valid", VLEN'(out_valid), '0);
        chk(req, "zero", result, '0);
    endtask

    task automatic t_reset;
        chk("R10", "valid", VLEN'(out_valid), '0);
        chk("R10", "undef", VLEN'(out_undef), '0);
        chk("R10", "data", result, '0);
    endtask

    task automatic t_sizes;
        run_ok("R3", 8, 1, pat(1));
        run_ok("R3", 16, 1, pat(2));
        run_ok("R3", 32, 1, pat(3));
        run_ok("R4", 8, 8, pat(4));
        run_ok("R4", 16, 16, pat(5));
        run_ok("R4", 32, 32, pat(6));
        run_ok("R8", 16, 9, pat(7));
    endtask

    task automatic t_rounding;
        logic [VLEN-1:0] v;
        v = '0;
        v[15:0] = 16'h0080; v[31:16] = 16'h007F; v[47:32] = 16'h01FF;
        issue(enc(8, 8, 5'd0, 5'd0), v);
        chk("R5", "boundary", result[31:0], {8'h00, 8'h00, 8'h00, 8'h01});
        chk("R5", "carry lane", result[47:32], 16'h0002);
        run_ok("R5", 32, 31, {VLEN{1'b1}});
        run_ok("R6", 16, 1, {VLEN{1'b1}});
        run_ok("R6", 8, 3, pat(9));
    endtask

    task automatic t_lanes;
        issue(enc(8, 1, 5'd1, 5'd2), pat(11));
        for (int e = 0; e < VLEN / 16; e++)
            chk("R7", "odd lane", VLEN'(result[e*16 + 8 +: 8]), '0);
    endtask

    task automatic t_undef;
        logic [31:0] g;
        g = enc(8, 1, 5'd0, 5'd0);
        run_bad("R1", {g[31:23], 1'b0, g[21], 2'b00, g[18:0]});
        run_bad("R2", g ^ 32'h8000_0000);
        run_bad("R2", g ^ 32'h0020_0000);
        run_bad("R2", g ^ 32'h0000_0400);
    endtask

    task automatic t_regidx;
        logic [VLEN-1:0] a;
        issue(enc(16, 5, 5'd0, 5'd0), pat(21));
        a = result;
        issue(enc(16, 5, 5'd31, 5'd17), pat(21));
        chk("R11", "index independence", result, a);
        chk("R11", "index data", result, model(16, 5, pat(21)));
    endtask

    task automatic t_timing;
        logic [VLEN-1:0] e1;
        @(negedge clk);
        in_valid = 1'b1; instr = enc(32, 4, 5'd0, 5'd0); src = pat(31);
        @(negedge clk);
        chk("R9", "first", result, model(32, 4, pat(31)));
        instr = enc(8, 2, 5'd0, 5'd0); src = pat(32);
        @(negedge clk);
        in_valid = 1'b0; src = pat(99); instr = enc(16, 1, 5'd0, 5'd0);
        e1 = model(8, 2, pat(32));
        chk("R9", "second", result, e1);
        @(negedge clk);
        chk("R9", "idle valid", VLEN'(out_valid), '0);
        chk("R9", "idle hold", result, e1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sizes();
        t_rounding();
        t_lanes();
        t_undef();
        t_regidx();
        t_timing();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule